// File: doc/BRIEF.md
# PCI Power Management Capability Registers

This block holds the two configuration-space dwords of a PCI power management capability for a single function, along with the logic that raises the wake request. The first dword is a fixed capability header. It carries the capability ID, a null next-capability pointer and the interface revision. The second dword is the control/status register. It holds the function's power state, a wake-enable bit and a sticky wake-status bit.

Configuration accesses arrive on a simple port. Each access carries a dword address, four byte enables and write data. Reads return their data one cycle after the request.

The power state after reset depends on a strap pin that is sampled while reset is held. The current power state is exported so that the surrounding function can act on it. A wake-event input sets the wake status. When both the status and the enable are set, the block drives the active-low wake output.

Top module: `pm_cap_regs`

## Requirements
- R1: A read of dword address 14h (byte 50h) returns the header value 0001_0001h. This is capability ID 01h in bits 7:0, next pointer 00h in bits 15:8 and version 1 in bits 18:16, with every other bit zero. Writes to this dword change nothing.
- R2: The control/status register sits at dword address 15h (byte 54h). Reads of any other dword address return zero, and writes to them change no state.
- R3: Bits 1:0 of the control/status register hold the power state as a read/write field, encoded 00=D0, 01=D1, 10=D2 and 11=D3. The `pwr_state` output always shows the stored value.
- R4: Synchronous reset does the following. It sets the power state to D3 if `strap_n` is low during reset and to D0 otherwise. It clears the enable and the status, drives `wake_n` high and drives `cfg_rvalid` low.
- R5: After reset is released, changes on `strap_n` do not alter the power state.
- R6: Bit 8 is the read/write wake enable and resets to 0. While it is 0, `wake_n` stays high.
- R7: A cycle with `wake_evt` high sets the status bit 15, whatever the value of the enable.
- R8: Writing 1 to bit 15 (lane 1 enabled) clears the status. Writing 0 to it has no effect.
- R9: `wake_n` is low exactly when the status and the enable are both 1. It changes at the same clock edge as the bits that cause it.
- R10: If a wake event and a write-one-to-clear of the status fall in the same cycle, the status stays set.
- R11: A write updates only the byte lanes whose `cfg_be` bit is high. Lane 0 holds bits 7:0 and lane 1 holds bits 15:8.
- R12: A read request (`cfg_req` high, `cfg_we` low) produces `cfg_rvalid` high with its data on the next cycle. Writes and idle cycles give `cfg_rvalid` low. Bits 31:16, 14:9 and 7:2 of the control/status register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_n | input | 1 | Reset-time strap; low selects D3 at reset |
| cfg_req | input | 1 | Configuration access request |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 6 | Dword address within configuration space |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read |
| wake_evt | input | 1 | Wake condition, one pulse per event |
| wake_n | output | 1 | Active-low wake request |
| pwr_state | output | 2 | Current power state |

## Verification
The wake-status bit has two sources that can act in the same cycle: a wake event that sets it and a configuration write of 1 to bit 15 that clears it. The bench drives `wake_evt` high in the same cycle as a lane-1 clear write while the enable is set. It then requires `wake_n` to remain low and a following read to show bit 15 still set. A clear without an event then confirms that the bit drops and that `wake_n` returns high on the same edge.

// File: rtl/pm_cap_pkg.sv
`timescale 1ns/1ps
package pm_cap_pkg;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pwr_state_e;

  // field positions inside the control/status dword
  localparam int PS_LSB   = 0;
  localparam int PS_MSB   = 1;
  localparam int EN_BIT   = 8;
  localparam int STS_BIT  = 15;
  localparam int PS_LANE  = PS_LSB / 8;
  localparam int EN_LANE  = EN_BIT / 8;
  localparam int STS_LANE = STS_BIT / 8;

  // header contents
  localparam logic [7:0] CAP_ID   = 8'h01;
  localparam logic [7:0] NEXT_PTR = 8'h00;
  localparam logic [2:0] PM_REV   = 3'd1;

  function automatic logic [DATA_W-1:0] header_word();
    logic [DATA_W-1:0] w;
    w = '0;
    w[7:0]   = CAP_ID;
    w[15:8]  = NEXT_PTR;
    w[18:16] = PM_REV;
    return w;
  endfunction
endpackage

// File: rtl/pm_addr_dec.sv
`timescale 1ns/1ps
module pm_addr_dec #(
  parameter int ADDR_W  = 6,
  parameter logic [ADDR_W-1:0] BASE_DW = 6'h14
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              hdr_hit,
  output logic              csr_hit,
  output logic              rd_req,
  output logic              csr_wr
);
  localparam logic [ADDR_W-1:0] CSR_DW = BASE_DW + 1'b1;

  always_comb begin
    hdr_hit = (addr == BASE_DW);
    csr_hit = (addr == CSR_DW);
    rd_req  = req && !we;
    csr_wr  = req && we && csr_hit;
  end
endmodule

// File: rtl/pm_csr_regs.sv
`timescale 1ns/1ps
module pm_csr_regs
  import pm_cap_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_n,
  input  logic             wr_en,
  input  logic [DW/8-1:0]  be,
  input  logic [DW-1:0]    wdata,
  input  logic             wake_evt,
  output pwr_state_e       pstate_q,
  output logic             en_q,
  output logic             sts_q,
  output logic             wake_n_q,
  output logic [DW-1:0]    csr_word
);
  pwr_state_e ps_d;
  logic       en_d, sts_d, clr_hit;

  // bits of the write word that no field uses
  logic unused_wbits;
  assign unused_wbits = ^{wdata[DW-1:STS_BIT+1], wdata[STS_BIT-1:EN_BIT+1],
                          wdata[EN_BIT-1:PS_MSB+1]};

  assign clr_hit = wr_en && be[STS_LANE] && wdata[STS_BIT];

  always_comb begin
    ps_d  = pstate_q;
    en_d  = en_q;
    sts_d = sts_q;
    if (wr_en && be[PS_LANE]) ps_d = pwr_state_e'(wdata[PS_MSB:PS_LSB]);
    if (wr_en && be[EN_LANE]) en_d = wdata[EN_BIT];
    if (clr_hit)              sts_d = 1'b0;
    if (wake_evt)             sts_d = 1'b1;   // event has priority over clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pstate_q <= strap_n ? PS_D0 : PS_D3;
      en_q     <= 1'b0;
      sts_q    <= 1'b0;
      wake_n_q <= 1'b1;
    end else begin
      pstate_q <= ps_d;
      en_q     <= en_d;
      sts_q    <= sts_d;
      wake_n_q <= !(sts_d && en_d);
    end
  end

  always_comb begin
    csr_word                 = '0;
    csr_word[PS_MSB:PS_LSB]  = pstate_q;
    csr_word[EN_BIT]         = en_q;
    csr_word[STS_BIT]        = sts_q;
  end

  assert_wake_pair_R9: assert property (@(posedge clk) disable iff (rst)
    wake_n_q == !(sts_q && en_q));
  assert_en_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> wake_n_q);
  assert_evt_sets_R7: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> sts_q);
  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !wake_evt) |=> !sts_q);
  assert_evt_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && wake_evt) |=> sts_q);
  assert_lane_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !be[PS_LANE]) |=> $stable(pstate_q));
  assert_strap_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(pstate_q));
endmodule

// File: rtl/pm_cfg_read.sv
`timescale 1ns/1ps
module pm_cfg_read
  import pm_cap_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic          hdr_hit,
  input  logic          csr_hit,
  input  logic [DW-1:0] csr_word,
  output logic [DW-1:0] rdata_q,
  output logic          rvalid_q
);
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (hdr_hit)      rd_mux = DW'(header_word());
    else if (csr_hit) rd_mux = csr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rd_mux;
    end
  end

  assert_rvalid_R12: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rvalid_q);
  assert_no_rvalid_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rvalid_q);
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !hdr_hit && !csr_hit) |=> (rdata_q == '0));
endmodule

// File: rtl/pm_cap_regs.sv
`timescale 1ns/1ps
module pm_cap_regs
  import pm_cap_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] BASE_DW = 6'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_n,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LANES-1:0]  cfg_be,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_rvalid,
  input  logic              wake_evt,
  output logic              wake_n,
  output logic [1:0]        pwr_state
);
  logic hdr_hit, csr_hit, rd_req, csr_wr;
  logic en_q, sts_q;
  pwr_state_e pstate_q;
  logic [DATA_W-1:0] csr_word;

  pm_addr_dec #(.ADDR_W(ADDR_W), .BASE_DW(BASE_DW)) u_dec (
    .req(cfg_req), .we(cfg_we), .addr(cfg_addr),
    .hdr_hit(hdr_hit), .csr_hit(csr_hit), .rd_req(rd_req), .csr_wr(csr_wr)
  );

  pm_csr_regs #(.DW(DATA_W)) u_csr (
    .clk(clk), .rst(rst), .strap_n(strap_n), .wr_en(csr_wr),
    .be(cfg_be), .wdata(cfg_wdata), .wake_evt(wake_evt),
    .pstate_q(pstate_q), .en_q(en_q), .sts_q(sts_q),
    .wake_n_q(wake_n), .csr_word(csr_word)
  );

  pm_cfg_read #(.DW(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_req(rd_req), .hdr_hit(hdr_hit),
    .csr_hit(csr_hit), .csr_word(csr_word),
    .rdata_q(cfg_rdata), .rvalid_q(cfg_rvalid)
  );

  assign pwr_state = pstate_q;
endmodule

// File: tb/pm_cap_regs_test.sv
`timescale 1ns/1ps
module pm_cap_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_n = 1'b1;
  logic        cfg_req = 1'b0, cfg_we = 1'b0, wake_evt = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid, wake_n;
  logic [1:0]  pwr_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  pm_cap_regs uut (
    .clk(clk), .rst(rst), .strap_n(strap_n), .cfg_req(cfg_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .wake_evt(wake_evt), .wake_n(wake_n), .pwr_state(pwr_state)
  );

  typedef struct packed {
    logic        req;
    logic        we;
    logic [5:0]  addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        evt;
    logic [31:0] exp_rd;
    logic        exp_wn;
    logic [1:0]  exp_ps;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,6'h14,4'h0,32'h0,        1'b0,32'h0001_0001,1'b1,2'd0,8'd1},  // R1 header
    '{1'b1,1'b0,6'h15,4'h0,32'h0,        1'b0,32'h0000_0000,1'b1,2'd0,8'd4},  // R4 csr after reset
    '{1'b1,1'b1,6'h15,4'h1,32'h2,        1'b0,32'h0,        1'b1,2'd2,8'd3},  // R3 write D2
    '{1'b1,1'b0,6'h15,4'h0,32'h0,        1'b0,32'h0000_0002,1'b1,2'd2,8'd3},  // R3 read back
    '{1'b1,1'b1,6'h15,4'h1,32'hFFFF_FFFF,1'b0,32'h0,        1'b1,2'd3,8'd11}, // R11 lane 0 only
    '{1'b1,1'b0,6'h15,4'h0,32'h0,        1'b0,32'h0000_0003,1'b1,2'd3,8'd12}, // R12 zero bits
    '{1'b0,1'b0,6'h00,4'h0,32'h0,        1'b1,32'h0,        1'b1,2'd3,8'd7},  // R7 event, en=0
    '{1'b1,1'b0,6'h15,4'h0,32'h0,        1'b0,32'h0000_8003,1'b1,2'd3,8'd6},  // R6 status w/o wake
    '{1'b1,1'b1,6'h15,4'h2,32'h0000_0100,1'b0,32'h0,        1'b0,2'd3,8'd9},  // R9 enable -> low
    '{1'b1,1'b0,6'h15,4'h0,32'h0,        1'b0,32'h0000_8103,1'b0,2'd3,8'd8},  // R8 write 0 kept
    '{1'b1,1'b1,6'h15,4'h2,32'h0000_8100,1'b0,32'h0,        1'b1,2'd3,8'd8},  // R8 clear
    '{1'b1,1'b0,6'h15,4'h0,32'h0,        1'b0,32'h0000_0103,1'b1,2'd3,8'd8},  // R8 read back
    '{1'b1,1'b1,6'h16,4'hF,32'hFFFF_FFFF,1'b0,32'h0,        1'b1,2'd3,8'd2},  // R2 stray write
    '{1'b1,1'b0,6'h16,4'h0,32'h0,        1'b0,32'h0000_0000,1'b1,2'd3,8'd2},  // R2 stray read
    '{1'b1,1'b0,6'h15,4'h0,32'h0,        1'b0,32'h0000_0103,1'b1,2'd3,8'd2},  // R2 csr unchanged
    '{1'b1,1'b1,6'h15,4'hC,32'hFFFF_FFFF,1'b0,32'h0,        1'b1,2'd3,8'd11}, // R11 upper lanes
    '{1'b1,1'b0,6'h15,4'h0,32'h0,        1'b0,32'h0000_0103,1'b1,2'd3,8'd11}, // R11 read back
    '{1'b1,1'b1,6'h14,4'hF,32'h0,        1'b0,32'h0,        1'b1,2'd3,8'd1},  // R1 header write
    '{1'b1,1'b0,6'h14,4'h0,32'h0,        1'b0,32'h0001_0001,1'b1,2'd3,8'd1},  // R1 header kept
    '{1'b1,1'b1,6'h15,4'h1,32'h0,        1'b0,32'h0,        1'b1,2'd0,8'd3}   // R3 back to D0
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic apply(input logic req, input logic we, input logic [5:0] addr,
                       input logic [3:0] be, input logic [31:0] wd, input logic evt);
    cfg_req = req; cfg_we = we; cfg_addr = addr; cfg_be = be;
    cfg_wdata = wd; wake_evt = evt;
    @(posedge clk); #1;
    cfg_req = 1'b0; cfg_we = 1'b0; wake_evt = 1'b0; cfg_be = '0;
  endtask

  task automatic do_reset(input logic strap);
    rst = 1'b1; strap_n = strap;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    do_reset(1'b1);
    // R4: reset state with strap high
    check("R4 pwr_state", {30'b0, pwr_state}, 32'd0);
    check("R4 wake_n", {31'b0, wake_n}, 32'd1);
    check("R4 rvalid", {31'b0, cfg_rvalid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      apply(v.req, v.we, v.addr, v.be, v.wd, v.evt);
      if (v.req && !v.we) begin
        check($sformatf("R%0d rvalid vec %0d", v.rq, i), {31'b0, cfg_rvalid}, 32'd1);
        check($sformatf("R%0d rdata vec %0d", v.rq, i), cfg_rdata, v.exp_rd);
      end else begin
        check($sformatf("R12 no rvalid vec %0d", i), {31'b0, cfg_rvalid}, 32'd0);
      end
      check($sformatf("R%0d wake_n vec %0d", v.rq, i), {31'b0, wake_n}, {31'b0, v.exp_wn});
      check($sformatf("R%0d pwr_state vec %0d", v.rq, i), {30'b0, pwr_state}, {30'b0, v.exp_ps});
    end

    // R10: event and clear in the same cycle, enable = 1, status = 0
    apply(1'b1, 1'b1, 6'h15, 4'h2, 32'h0000_8100, 1'b1);
    check("R10 wake_n stays low", {31'b0, wake_n}, 32'd0);
    apply(1'b1, 1'b0, 6'h15, 4'h0, 32'h0, 1'b0);
    check("R10 status kept", cfg_rdata, 32'h0000_8100);
    apply(1'b1, 1'b1, 6'h15, 4'h2, 32'h0000_8100, 1'b0);
    check("R9 wake_n released", {31'b0, wake_n}, 32'd1);
    // R9/R7: event with enable set drives wake_n low on the same edge
    apply(1'b0, 1'b0, 6'h00, 4'h0, 32'h0, 1'b1);
    check("R9 wake on event", {31'b0, wake_n}, 32'd0);

    // R4: reset with strap low selects D3, clears wake state
    do_reset(1'b0);
    check("R4 strap low D3", {30'b0, pwr_state}, 32'd3);
    check("R4 wake_n after reset", {31'b0, wake_n}, 32'd1);
    apply(1'b1, 1'b0, 6'h15, 4'h0, 32'h0, 1'b0);
    check("R4 csr after strap-low reset", cfg_rdata, 32'h0000_0003);

    // R5: strap ignored once reset is released
    strap_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check("R5 strap ignored", {30'b0, pwr_state}, 32'd3);
    apply(1'b1, 1'b1, 6'h15, 4'h1, 32'h1, 1'b0);
    strap_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R5 D1 kept with strap low", {30'b0, pwr_state}, 32'd1);

    done = 1'b1;
    finish_run();
  end
endmodule